// File: doc/BRIEF.md
# Eight-Way Tree Pseudo-LRU Victim Selector

This block keeps the replacement history for every set of an eight-way set-associative cache and names the way to evict when a miss has to be filled. Each set owns a seven-bit binary tree. A lookup reads the tree of the addressed set and the set's valid vector, and returns a victim way in the same cycle. Empty ways always win over the tree. Only when the set is full does the tree decide.

The cache controller reports each hit or fill through an access strobe and the way number. That access turns every tree node on the way's path to point at the opposite half, so the way just used is not the next victim. A locked access that produced no way is reported with a separate "no way" flag, and the tree is then left alone. A synchronous clear request empties the history of all sets at once.

Top module: `plru8_victim_sel`

## Requirements
- R1: After a synchronous active-low reset, all seven tree bits of every set are 0. With all ways valid, the victim of any set is then way 0.
- R2: When `clear_i` is high at a clock edge, the tree bits of every set become 0 at that edge.
- R3: If `valid_vec_i` (bit k set means way k is valid) is not all ones, `victim_o` is the lowest way number whose valid bit is 0.
- R4: If all eight ways are valid, the victim is taken from tree bits t0..t6. When t0=1, t2=1 selects between way 7 (t6=1) and way 6 (t6=0), and t2=0 selects between way 5 (t5=1) and way 4 (t5=0). When t0=0, t1=1 selects between way 3 (t4=1) and way 2 (t4=0), and t1=0 selects between way 1 (t3=1) and way 0 (t3=0).
- R5: An access to way w changes only the three nodes on w's path, and sets each of them to point away from w. Way 0 gives t0=1, t1=1, t3=1. Way 1 gives t0=1, t1=1, t3=0. Way 2 gives t0=1, t1=0, t4=1. Way 3 gives t0=1, t1=0, t4=0. Way 4 gives t0=0, t2=1, t5=1. Way 5 gives t0=0, t2=1, t5=0. Way 6 gives t0=0, t2=0, t6=1. Way 7 gives t0=0, t2=0, t6=0.
- R6: An access with `acc_none_i` high leaves the tree of the set unchanged.
- R7: `victim_o` is combinational from the current state. An access presented in cycle N changes the victim seen in cycle N+1, not in cycle N.
- R8: An access updates only the tree of the set given by `set_idx_i`. Other sets keep their state.
- R9: When `clear_i` and an access fall in the same cycle, the clear takes priority and the addressed set also ends with all bits 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clear_i | input | 1 | Clear the history of all sets |
| set_idx_i | input | SET_W | Set addressed by the lookup and by the access |
| valid_vec_i | input | 8 | Valid bits of the addressed set, bit k for way k |
| acc_en_i | input | 1 | A hit or fill takes place this cycle |
| acc_none_i | input | 1 | The access selected no way, so skip the update |
| acc_way_i | input | 3 | Way that was hit or filled |
| victim_o | output | 3 | Way to replace in the addressed set |

## Verification
The checker assumes that at most one access is reported per cycle and that the same set index serves both the lookup and the update. It also assumes that `acc_way_i` is meaningful only when `acc_en_i` is high and `acc_none_i` is low. The "steer away" and "skip" properties compare a cycle with the next one, and they apply only when the set index is held. The bench holds the index for those pairs. Its random phase changes the index every cycle within sixteen sets, so that the independence of sets is exercised while the properties' preconditions still come up often.

// File: rtl/plru8_pkg.sv
// Package: shared widths and types for the eight-way pseudo-LRU selector.
// Assumes a power-of-two way count. The tree has WAYS-1 nodes, stored in
// heap order: node n has children 2n+1 and 2n+2.
package plru8_pkg;
    localparam int WAYS   = 8;
    localparam int WAY_W  = $clog2(WAYS);
    localparam int TREE_W = WAYS - 1;

    typedef logic [TREE_W-1:0] tree_t;
    typedef logic [WAY_W-1:0]  way_t;
    typedef logic [WAYS-1:0]   vmask_t;
endpackage

// File: rtl/plru8_tree_update.sv
// Module: plru8_tree_update
// Computes the next tree of one set after an access to a given way. Each
// node on the way's path is written with the inverse of the way bit at that
// level, which steers the node toward the other half. Nodes off the path
// keep their values. Purely combinational.
module plru8_tree_update
    import plru8_pkg::*;
(
    input  tree_t cur_i,
    input  way_t  way_i,
    output tree_t nxt_o
);
    // Walk the levels from the root and overwrite the path nodes.
    always_comb begin
        int node;
        nxt_o = cur_i;
        node  = 0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            nxt_o[node] = ~way_i[WAY_W-1-lvl];
            node = 2 * node + 1 + int'(way_i[WAY_W-1-lvl]);
        end
    end
endmodule

// File: rtl/plru8_victim_pick.sv
// Module: plru8_victim_pick
// Picks the victim of one set. The lowest invalid way wins whenever one
// exists. Otherwise the tree is walked from the root, and each node bit gives
// the next way bit. Purely combinational. Assumes a valid vector from the
// tag side.
module plru8_victim_pick
    import plru8_pkg::*;
(
    input  tree_t  tree_i,
    input  vmask_t valid_i,
    output way_t   victim_o
);
    way_t free_way;
    way_t tree_way;
    logic any_free;

    // Priority encoder: find the lowest-numbered invalid way.
    always_comb begin
        free_way = '0;
        any_free = 1'b0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!valid_i[w]) begin
                free_way = way_t'(w);
                any_free = 1'b1;
            end
        end
    end

    // Tree walk: the node at each level supplies one way bit, MSB first.
    always_comb begin
        int node;
        tree_way = '0;
        node     = 0;
        for (int lvl = 0; lvl < WAY_W; lvl++) begin
            tree_way[WAY_W-1-lvl] = tree_i[node];
            node = 2 * node + 1 + int'(tree_i[node]);
        end
    end

    // Final choice: free ways take precedence over the tree.
    assign victim_o = any_free ? free_way : tree_way;
endmodule

// File: rtl/plru8_state_array.sv
// Module: plru8_state_array
// Register array that holds one tree per set. It has one asynchronous read
// port and one write port, both for the same cycle's set. A synchronous
// active-low reset or a clear request zeroes every set, and the clear wins
// over a write.
module plru8_state_array
    import plru8_pkg::*;
#(
    parameter int NUM_SETS = 128,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [SET_W-1:0] idx_i,
    input  logic             we_i,
    input  tree_t            wdata_i,
    output tree_t            rdata_o
);
    tree_t mem [NUM_SETS];

    // Storage: reset or clear empties all sets, otherwise write the addressed set.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                mem[s] <= '0;
            end
        end else if (we_i) begin
            mem[idx_i] <= wdata_i;
        end
    end

    // Read port: the tree of the addressed set.
    assign rdata_o = mem[idx_i];
endmodule

// File: rtl/plru8_victim_sel.sv
// Module: plru8_victim_sel (top)
// Eight-way tree pseudo-LRU victim selector. One set index serves both the
// victim lookup and the access update in a cycle. The update is skipped when
// the access carries the no-way flag. Assumes at most one access per cycle.
module plru8_victim_sel
    import plru8_pkg::*;
#(
    parameter int NUM_SETS = 128,
    localparam int SET_W   = $clog2(NUM_SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic [SET_W-1:0] set_idx_i,
    input  logic [7:0]       valid_vec_i,
    input  logic             acc_en_i,
    input  logic             acc_none_i,
    input  logic [2:0]       acc_way_i,
    output logic [2:0]       victim_o
);
    tree_t cur_tree;
    tree_t nxt_tree;
    logic  upd_en;

    // Update gate: only real hits or fills touch the tree.
    assign upd_en = acc_en_i && !acc_none_i;

    plru8_state_array #(.NUM_SETS(NUM_SETS)) u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .idx_i   (set_idx_i),
        .we_i    (upd_en),
        .wdata_i (nxt_tree),
        .rdata_o (cur_tree)
    );

    plru8_tree_update u_upd (
        .cur_i (cur_tree),
        .way_i (acc_way_i),
        .nxt_o (nxt_tree)
    );

    plru8_victim_pick u_pick (
        .tree_i   (cur_tree),
        .valid_i  (valid_vec_i),
        .victim_o (victim_o)
    );
endmodule

// File: rtl/plru8_sel_chk.sv
// Module: plru8_sel_chk
// Property checker for plru8_victim_sel, attached through bind. Assumes one
// access per cycle and a set index shared by lookup and update.
module plru8_sel_chk #(
    parameter int SET_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             clear_i,
    input logic [SET_W-1:0] set_idx_i,
    input logic [7:0]       valid_vec_i,
    input logic             acc_en_i,
    input logic             acc_none_i,
    input logic [2:0]       acc_way_i,
    input logic [2:0]       victim_o,
    input logic [6:0]       cur_tree
);
    // Clear leaves every set empty, so the tree read back is zero (R2).
    p_clear_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(clear_i) |-> cur_tree == 7'd0);

    // With a free way, the victim is free and every lower way is valid (R3).
    p_lowest_free_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_vec_i != 8'hFF) |->
        (!valid_vec_i[victim_o] &&
         ((valid_vec_i & ((8'd1 << victim_o) - 8'd1)) == ((8'd1 << victim_o) - 8'd1))));

    // A real access steers the full set away from the way just used (R5).
    p_steer_away_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && !acc_none_i && !clear_i) ##1
        (set_idx_i == $past(set_idx_i) && valid_vec_i == 8'hFF)
        |-> victim_o != $past(acc_way_i));

    // An access with no way leaves the addressed tree untouched (R6).
    p_skip_none_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en_i && acc_none_i && !clear_i) ##1 (set_idx_i == $past(set_idx_i))
        |-> cur_tree == $past(cur_tree));
endmodule

bind plru8_victim_sel plru8_sel_chk #(.SET_W(SET_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .clear_i     (clear_i),
    .set_idx_i   (set_idx_i),
    .valid_vec_i (valid_vec_i),
    .acc_en_i    (acc_en_i),
    .acc_none_i  (acc_none_i),
    .acc_way_i   (acc_way_i),
    .victim_o    (victim_o),
    .cur_tree    (cur_tree)
);

// File: tb/sim_plru8_victim_sel.sv
`timescale 1ns/1ps
module sim_plru8_victim_sel;
    localparam int NSETS = 128;
    localparam int SW    = $clog2(NSETS);

    // Table: {way accessed, expected full-set victim afterwards}, walked on set 3 (R4, R5)
    localparam logic [5:0] STEP_TBL [8] = '{
        {3'd0, 3'd4}, {3'd4, 3'd2}, {3'd2, 3'd6}, {3'd6, 3'd1},
        {3'd1, 3'd5}, {3'd5, 3'd3}, {3'd3, 3'd7}, {3'd7, 3'd0}
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clear_i = 1'b0;
    logic [SW-1:0] set_idx_i = '0;
    logic [7:0]    valid_vec_i = 8'hFF;
    logic          acc_en_i = 1'b0;
    logic          acc_none_i = 1'b0;
    logic [2:0]    acc_way_i = '0;
    logic [2:0]    victim_o;

    int n_chk  = 0;
    int n_fail = 0;
    logic [6:0] mdl [NSETS];

    always #2.5 clk = ~clk;

    plru8_victim_sel #(.NUM_SETS(NSETS)) u0 (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .set_idx_i(set_idx_i),
        .valid_vec_i(valid_vec_i), .acc_en_i(acc_en_i), .acc_none_i(acc_none_i),
        .acc_way_i(acc_way_i), .victim_o(victim_o)
    );

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    task automatic check(input string req, input logic [2:0] act, input logic [2:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: victim actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Move to just after the next rising edge
    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Reference victim from R3/R4
    function automatic logic [2:0] ref_victim(input logic [6:0] t, input logic [7:0] v);
        for (int w = 0; w < 8; w++) if (!v[w]) return 3'(w);
        if (t[0]) begin
            if (t[2]) return t[6] ? 3'd7 : 3'd6;
            else      return t[5] ? 3'd5 : 3'd4;
        end else begin
            if (t[1]) return t[4] ? 3'd3 : 3'd2;
            else      return t[3] ? 3'd1 : 3'd0;
        end
    endfunction

    // Reference update from R5
    function automatic logic [6:0] ref_update(input logic [6:0] t, input logic [2:0] w);
        logic [6:0] n = t;
        case (w)
            3'd0: begin n[0] = 1; n[1] = 1; n[3] = 1; end
            3'd1: begin n[0] = 1; n[1] = 1; n[3] = 0; end
            3'd2: begin n[0] = 1; n[1] = 0; n[4] = 1; end
            3'd3: begin n[0] = 1; n[1] = 0; n[4] = 0; end
            3'd4: begin n[0] = 0; n[2] = 1; n[5] = 1; end
            3'd5: begin n[0] = 0; n[2] = 1; n[5] = 0; end
            3'd6: begin n[0] = 0; n[2] = 0; n[6] = 1; end
            default: begin n[0] = 0; n[2] = 0; n[6] = 0; end
        endcase
        return n;
    endfunction

    task automatic access(input int s, input logic [2:0] w, input logic none);
        set_idx_i = SW'(s); acc_en_i = 1'b1; acc_way_i = w; acc_none_i = none;
        tick();
        acc_en_i = 1'b0; acc_none_i = 1'b0;
    endtask

    task automatic look(input int s, input logic [7:0] v);
        set_idx_i = SW'(s); valid_vec_i = v;
        #1;
    endtask

    initial begin
        #(5.0 * 190000);
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        finish_run();
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state, full set gives way 0
        for (int s = 0; s < 4; s++) begin
            look(s * 37, 8'hFF);
            check("R1 reset", victim_o, 3'd0);
        end

        // R4/R5: table walk on set 3
        foreach (STEP_TBL[i]) begin
            access(3, STEP_TBL[i][5:3], 1'b0);
            look(3, 8'hFF);
            check("R4/R5 table", victim_o, STEP_TBL[i][2:0]);
        end

        // R3: fill an empty set in order 0..7
        begin
            logic [7:0] v = 8'h00;
            for (int k = 0; k < 8; k++) begin
                look(9, v);
                check("R3 fill order", victim_o, 3'(k));
                access(9, 3'(k), 1'b0);
                v[k] = 1'b1;
            end
        end
        look(9, 8'b1011_0111);
        check("R3 lowest hole", victim_o, 3'd3);

        // R7: access is not visible in its own cycle, visible in the next
        set_idx_i = SW'(20); valid_vec_i = 8'hFF;
        acc_en_i = 1'b1; acc_way_i = 3'd0; acc_none_i = 1'b0;
        #1;
        check("R7 same cycle", victim_o, 3'd0);
        tick();
        acc_en_i = 1'b0;
        #1;
        check("R7 next cycle", victim_o, 3'd4);

        // R8: neighbouring set untouched
        look(21, 8'hFF);
        check("R8 other set", victim_o, 3'd0);

        // R6: no-way access leaves state alone
        access(20, 3'd4, 1'b1);
        look(20, 8'hFF);
        check("R6 no way", victim_o, 3'd4);

        // R2: clear zeroes every set
        clear_i = 1'b1; tick(); clear_i = 1'b0;
        look(3, 8'hFF);  check("R2 clear set 3", victim_o, 3'd0);
        look(20, 8'hFF); check("R2 clear set 20", victim_o, 3'd0);

        // R9: clear wins over a same-cycle access
        clear_i = 1'b1; access(30, 3'd0, 1'b0); clear_i = 1'b0;
        look(30, 8'hFF);
        check("R9 clear priority", victim_o, 3'd0);

        // R1: a second reset empties a used set
        access(31, 3'd7, 1'b0);
        rst_n = 1'b0; tick(); rst_n = 1'b1; tick();
        look(31, 8'hFF);
        check("R1 re-reset", victim_o, 3'd0);

        // R3/R4/R5/R6/R8: random traffic against the reference model
        for (int s = 0; s < NSETS; s++) mdl[s] = '0;
        for (int i = 0; i < 3000; i++) begin
            int s = int'($urandom_range(0, 15));
            logic [7:0] v = ($urandom_range(0, 3) == 0) ? 8'($urandom) : 8'hFF;
            logic [2:0] w = 3'($urandom);
            logic en = ($urandom_range(0, 9) < 8);
            logic nn = ($urandom_range(0, 9) == 0);
            look(s, v);
            check("R4 random", victim_o, ref_victim(mdl[s], v));
            set_idx_i = SW'(s); acc_en_i = en; acc_way_i = w; acc_none_i = nn;
            tick();
            acc_en_i = 1'b0; acc_none_i = 1'b0;
            if (en && !nn) mdl[s] = ref_update(mdl[s], w);
        end

        finish_run();
    end
endmodule